// File: doc/BRIEF.md
# Transmit Driver-Enable Sequencer

This block produces the driver-enable (RTS) line for a half-duplex, RS-485 style serial link. It sits beside a serial transmitter. It watches the transmit queue and the transmitter's busy flag. In automatic mode it raises the enable a programmed lead time before the first start bit may go out. It keeps the enable raised for a programmed lag time after the last stop bit. It also gives the transmitter a permit-to-start signal.

Lead and lag are counted in ticks from one of two sources, chosen by a configuration bit: system-clock ticks or bit-time (baud) ticks. The output polarity is programmable. An optional gate, with its own polarity, lets a new character start only while the far end asserts CTS. In manual mode a software level drives the enable directly and no sequencing takes place. All configuration inputs are plain static levels. There is no streamed data path, so the block has no valid/ready interface.

Top module: `txen_sequencer`

## Requirements
- R1: After reset, and whenever automatic mode is idle, `rts_out` is at its inactive level and `start_ok` is low.
- R2: In automatic mode, `rts_out` turns active on the first clock edge at which `txq_nonempty` is seen high while idle. `start_ok` rises on the edge that consumes the `cfg_lead`-th selected tick after that entry edge.
- R3: With `cfg_lead` = 0, the lead phase is skipped: `rts_out` and `start_ok` both turn active on the entry edge.
- R4: Once `txq_nonempty` and `tx_busy` are both low during transmission, `rts_out` stays active until the `cfg_lag`-th selected tick and then returns inactive.
- R5: With `cfg_lag` = 0, the lag phase is skipped: `rts_out` goes inactive on the first edge at which the queue is empty and the transmitter is idle.
- R6: If `txq_nonempty` (or `tx_busy`) rises during the lag phase, the block returns to transmission on the next edge with `start_ok` high and no new lead phase.
- R7: While `tx_busy` is high in automatic mode, `rts_out` stays active.
- R8: `cfg_count_clk` = 1 counts `sys_tick`; `cfg_count_clk` = 0 counts `baud_tick`. Pulses on the unselected tick input have no effect on the timing.
- R9: `cfg_rts_high` = 1 makes `rts_out` high when active; `cfg_rts_high` = 0 makes it low when active.
- R10: With `cfg_auto` = 0, `rts_out` shows `cfg_sw_level` (through the polarity) in the same cycle. `start_ok` then depends only on the CTS gate.
- R11: With `cfg_cts_gate` = 1, `start_ok` is high only while CTS is asserted. CTS counts as asserted when `cts_in` equals `cfg_cts_high`, seen through a `SYNC_STAGES`-flop synchronizer (2 clock edges by default). With the gate off, `cts_in` has no effect.
- R12: In automatic mode, `start_ok` is high only in the transmission phase: never while idle, in the lead phase or in the lag phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_auto | input | 1 | 1 = automatic sequencing, 0 = manual level |
| cfg_sw_level | input | 1 | Manual enable level (1 = active) |
| cfg_count_clk | input | 1 | Tick source: 1 = system ticks, 0 = baud ticks |
| cfg_lead | input | CNT_W | Lead ticks before the first start bit |
| cfg_lag | input | CNT_W | Lag ticks after the last stop bit |
| cfg_rts_high | input | 1 | Output polarity: 1 = active high |
| cfg_cts_gate | input | 1 | Enables CTS gating of `start_ok` |
| cfg_cts_high | input | 1 | CTS polarity: 1 = active high |
| sys_tick | input | 1 | System-clock tick strobe |
| baud_tick | input | 1 | Bit-time tick strobe |
| txq_nonempty | input | 1 | Transmit queue holds data |
| tx_busy | input | 1 | Transmitter is shifting a character |
| cts_in | input | 1 | Raw CTS line from the far end |
| rts_out | output | 1 | Driver-enable / RTS pin level |
| start_ok | output | 1 | Permit for the transmitter to begin a new character |

## Verification
The phase state is the only register between a request and the outputs. A change of `txq_nonempty` or `tx_busy` therefore shows on `rts_out` and `start_ok` one clock edge later. Lead and lag end on the edge that consumes their last selected tick. Manual level, polarity and turning the gate off act within the same cycle. A CTS change reaches `start_ok` after the two synchronizer edges. The bench drives at the falling edge and queues one expected output pair per rising edge. A monitor compares each pair just after that rising edge, so every check lands on the exact cycle worked out above.

// File: rtl/txen_pkg.sv
package txen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,
    PH_SEND = 2'd2,
    PH_HOLD = 2'd3
  } phase_e;
endpackage

// File: rtl/txen_cts_sync.sv
module txen_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic s0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s0 <= 1'b0;
        else        s0 <= d;
      end
      assign q = s0;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/txen_delay_ctr.sv
module txen_delay_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_sys,
  input  logic             sys_tick,
  input  logic             baud_tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic             tick;
  logic [CNT_W-1:0] remain;

  assign tick = sel_sys ? sys_tick : baud_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         remain <= '0;
    else if (load)                      remain <= load_val;
    else if (tick && (remain != '0))    remain <= remain - 1'b1;
  end

  // final tick of a running count
  assign last = !load && tick && (remain == CNT_W'(1));
endmodule

// File: rtl/txen_phase_fsm.sv
module txen_phase_fsm
  import txen_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   auto_en,
  input  logic   txq_nonempty,
  input  logic   tx_busy,
  input  logic   lead_zero,
  input  logic   lag_zero,
  input  logic   ctr_last,
  output phase_e phase,
  output logic   ctr_load,
  output logic   pick_lag
);
  phase_e nxt;

  always_comb begin
    nxt      = phase;
    ctr_load = 1'b0;
    pick_lag = 1'b0;
    if (!auto_en) begin
      nxt = PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE: if (txq_nonempty) begin
          if (lead_zero) nxt = PH_SEND;
          else begin
            nxt      = PH_LEAD;
            ctr_load = 1'b1;
          end
        end
        PH_LEAD: if (ctr_last) nxt = PH_SEND;
        PH_SEND: if (!txq_nonempty && !tx_busy) begin
          if (lag_zero) nxt = PH_IDLE;
          else begin
            nxt      = PH_HOLD;
            ctr_load = 1'b1;
            pick_lag = 1'b1;
          end
        end
        PH_HOLD: begin
          if (txq_nonempty || tx_busy) nxt = PH_SEND;
          else if (ctr_last)           nxt = PH_IDLE;
        end
        default: nxt = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end
endmodule

// File: rtl/txen_sequencer.sv
module txen_sequencer
  import txen_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_auto,
  input  logic             cfg_sw_level,
  input  logic             cfg_count_clk,
  input  logic [CNT_W-1:0] cfg_lead,
  input  logic [CNT_W-1:0] cfg_lag,
  input  logic             cfg_rts_high,
  input  logic             cfg_cts_gate,
  input  logic             cfg_cts_high,
  input  logic             sys_tick,
  input  logic             baud_tick,
  input  logic             txq_nonempty,
  input  logic             tx_busy,
  input  logic             cts_in,
  output logic             rts_out,
  output logic             start_ok
);
  phase_e           phase;
  logic             ctr_load, pick_lag, ctr_last;
  logic [CNT_W-1:0] load_val;
  logic             cts_s, cts_ok, rts_logic;

  assign load_val = pick_lag ? cfg_lag : cfg_lead;

  txen_delay_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_sys  (cfg_count_clk),
    .sys_tick (sys_tick),
    .baud_tick(baud_tick),
    .load     (ctr_load),
    .load_val (load_val),
    .last     (ctr_last)
  );

  txen_phase_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .auto_en     (cfg_auto),
    .txq_nonempty(txq_nonempty),
    .tx_busy     (tx_busy),
    .lead_zero   (cfg_lead == '0),
    .lag_zero    (cfg_lag == '0),
    .ctr_last    (ctr_last),
    .phase       (phase),
    .ctr_load    (ctr_load),
    .pick_lag    (pick_lag)
  );

  txen_cts_sync #(.STAGES(SYNC_STAGES)) u_cts (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (cts_in),
    .q    (cts_s)
  );

  assign cts_ok    = !cfg_cts_gate || (cts_s == cfg_cts_high);
  assign rts_logic = cfg_auto ? (phase != PH_IDLE) : cfg_sw_level;
  assign rts_out   = rts_logic ~^ cfg_rts_high;
  assign start_ok  = (cfg_auto ? (phase == PH_SEND) : 1'b1) && cts_ok;
endmodule

// File: rtl/txen_sequencer_chk.sv
module txen_sequencer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_auto,
  input logic [CNT_W-1:0] cfg_lead,
  input logic             cfg_rts_high,
  input logic             cfg_cts_gate,
  input logic             cfg_cts_high,
  input logic             txq_nonempty,
  input logic             tx_busy,
  input logic             cts_in,
  input logic             rts_out,
  input logic             start_ok
);
  logic       rts_act;
  logic [1:0] age;

  assign rts_act = (rts_out == cfg_rts_high);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  assert_permit_needs_rts_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_auto && start_ok |-> rts_act);

  assert_lead_blocks_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0) && cfg_auto && $past(cfg_auto) && $stable(cfg_rts_high)
    && $rose(rts_act) && ($past(cfg_lead) != '0) |-> !start_ok);

  assert_drop_after_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0) && cfg_auto && $past(cfg_auto) && $stable(cfg_rts_high)
    && $fell(rts_act) |-> $past(!txq_nonempty && !tx_busy));

  assert_busy_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0) && cfg_auto && $past(cfg_auto) && $stable(cfg_rts_high)
    && $past(rts_act) && $past(tx_busy) |-> rts_act);

  assert_cts_gates_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) && cfg_cts_gate && start_ok && ($past(cfg_cts_high, 2) == cfg_cts_high)
    |-> ($past(cts_in, 2) == cfg_cts_high));
endmodule

bind txen_sequencer txen_sequencer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_auto    (cfg_auto),
  .cfg_lead    (cfg_lead),
  .cfg_rts_high(cfg_rts_high),
  .cfg_cts_gate(cfg_cts_gate),
  .cfg_cts_high(cfg_cts_high),
  .txq_nonempty(txq_nonempty),
  .tx_busy     (tx_busy),
  .cts_in      (cts_in),
  .rts_out     (rts_out),
  .start_ok    (start_ok)
);

// File: tb/test_txen_sequencer.sv
module test_txen_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_auto = 1'b1, cfg_sw_level = 1'b0, cfg_count_clk = 1'b1;
  logic [CNT_W-1:0] cfg_lead = 8'd3, cfg_lag = 8'd2;
  logic cfg_rts_high = 1'b1, cfg_cts_gate = 1'b0, cfg_cts_high = 1'b1;
  logic sys_tick = 1'b1, baud_tick = 1'b0;
  logic txq_nonempty = 1'b0, tx_busy = 1'b0, cts_in = 1'b0;
  logic rts_out, start_ok;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic  rts;
    logic  ok;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  txen_sequencer #(.CNT_W(CNT_W), .SYNC_STAGES(2)) i_txen_sequencer (
    .clk(clk), .rst_n(rst_n), .cfg_auto(cfg_auto), .cfg_sw_level(cfg_sw_level),
    .cfg_count_clk(cfg_count_clk), .cfg_lead(cfg_lead), .cfg_lag(cfg_lag),
    .cfg_rts_high(cfg_rts_high), .cfg_cts_gate(cfg_cts_gate), .cfg_cts_high(cfg_cts_high),
    .sys_tick(sys_tick), .baud_tick(baud_tick), .txq_nonempty(txq_nonempty),
    .tx_busy(tx_busy), .cts_in(cts_in), .rts_out(rts_out), .start_ok(start_ok)
  );

  task automatic check(string tag, string what, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // driver side: queue the outputs due after the next rising edge
  task automatic expect_cycle(logic r, logic s, string tag);
    exp_t e;
    e.rts = r; e.ok = s; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  // monitor side
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "rts_out", rts_out, e.rts);
        check(e.tag, "start_ok", start_ok, e.ok);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    check("R1", "rts_out in reset", rts_out, 1'b0);
    check("R1", "start_ok in reset", start_ok, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    expect_cycle(0, 0, "R1");
    expect_cycle(0, 0, "R1");

    // R2 / R12: lead of 3 system ticks
    txq_nonempty = 1'b1;
    expect_cycle(1, 0, "R2");
    expect_cycle(1, 0, "R12");
    expect_cycle(1, 0, "R12");
    expect_cycle(1, 1, "R2");
    // R7: queue drained, transmitter still busy
    txq_nonempty = 1'b0; tx_busy = 1'b1;
    for (int i = 0; i < 3; i++) expect_cycle(1, 1, "R7");
    // R4: lag of 2 ticks
    tx_busy = 1'b0;
    expect_cycle(1, 0, "R4");
    expect_cycle(1, 0, "R4");
    expect_cycle(0, 0, "R4");

    // R3 zero lead, R6 retrigger during lag, R5 zero lag
    cfg_lead = 8'd0;
    txq_nonempty = 1'b1;
    expect_cycle(1, 1, "R3");
    txq_nonempty = 1'b0;
    expect_cycle(1, 0, "R12");
    txq_nonempty = 1'b1;
    expect_cycle(1, 1, "R6");
    cfg_lag = 8'd0;
    txq_nonempty = 1'b0;
    expect_cycle(0, 0, "R5");

    // R8: baud ticks counted, system ticks ignored
    cfg_count_clk = 1'b0; cfg_lead = 8'd2;
    txq_nonempty = 1'b1;
    for (int c = 0; c < 8; c++) begin
      baud_tick = (c == 3 || c == 7);
      expect_cycle(1, (c == 7), "R8");
    end
    baud_tick = 1'b0;
    txq_nonempty = 1'b0;
    expect_cycle(0, 0, "R8");
    cfg_count_clk = 1'b1;

    // R9: active-low output
    cfg_rts_high = 1'b0;
    expect_cycle(1, 0, "R9");
    cfg_lead = 8'd0; txq_nonempty = 1'b1;
    expect_cycle(0, 1, "R9");
    txq_nonempty = 1'b0;
    expect_cycle(1, 0, "R9");
    cfg_rts_high = 1'b1;
    expect_cycle(0, 0, "R9");

    // R10: manual mode
    cfg_auto = 1'b0; cfg_sw_level = 1'b1;
    expect_cycle(1, 1, "R10");
    cfg_sw_level = 1'b0; cfg_lead = 8'd3; txq_nonempty = 1'b1;
    expect_cycle(0, 1, "R10");
    expect_cycle(0, 1, "R10");
    txq_nonempty = 1'b0; cfg_auto = 1'b1;
    expect_cycle(0, 0, "R10");

    // R11: CTS gating, active-low CTS, deasserted at first
    cfg_cts_gate = 1'b1; cfg_cts_high = 1'b0; cts_in = 1'b1;
    expect_cycle(0, 0, "R11");
    expect_cycle(0, 0, "R11");
    cfg_lead = 8'd0; txq_nonempty = 1'b1;
    expect_cycle(1, 0, "R11");
    expect_cycle(1, 0, "R11");
    cts_in = 1'b0;
    expect_cycle(1, 0, "R11");
    expect_cycle(1, 1, "R11");
    cts_in = 1'b1;
    expect_cycle(1, 1, "R11");
    expect_cycle(1, 0, "R11");
    cfg_cts_gate = 1'b0;
    expect_cycle(1, 1, "R11");
    txq_nonempty = 1'b0;
    expect_cycle(0, 0, "R5");

    expect_cycle(0, 0, "R1");
    @(negedge clk);
    finish_run();
  end
endmodule